// File: doc/BRIEF.md
# Secure Watchdog Timer

This block is a countdown watchdog that asks the chip-level reset controller to reset the system when software stops servicing it. Software programs a timeout value, sets a one-way arm bit, and then refreshes the counter by writing two fixed key bytes, one after the other, to a feed register. Once armed, the watchdog cannot be switched off by software, and its mode cannot be changed.

The count advances through a fixed divide-by-4 prescaler, so the interval runs from about a thousand clocks up to minutes at the full 32-bit limit. A debug option, chosen before arming, turns expiry into an interrupt with automatic reload instead of a reset request. A sticky flag records that an expiry occurred. The flag, the arm bit, the mode bit and the timeout survive the system reset that the watchdog itself causes, and only power-on reset clears them. The live count can be read in the same cycle as the request.

Top module: `sentry_wdt`

## Requirements
- R1: After power-on reset, CTRL (address 0) reads 0, LIMIT (address 1) reads 0x000000FF, FEED (address 2) and COUNT (address 3) read 0, and both sys_rst_req and irq are low.
- R2: A write to LIMIT stores the written value, except that a value below 0xFF is stored as 0xFF. LIMIT reads back the stored value.
- R3: While armed (CTRL bit 0 = 1), a write of 0xAA to FEED (low 8 bits), followed by a write of 0x55 to FEED as the very next bus access, loads COUNT from LIMIT and starts the count (CTRL bit 3 = 1). The same pair has no effect while unarmed.
- R4: Any other bus access, read or write, between the 0xAA and 0x55 writes voids the feed, so the count is neither reloaded nor restarted.
- R5: While running, COUNT decreases by one every 4 clocks, and a read returns the current value combinationally in the cycle of the request. Reads return 0 when req_valid is low or req_write is high.
- R6: In reset mode (CTRL bit 1 = 0), sys_rst_req rises 4*(LIMIT+1) clock edges after the edge that completes a feed and stays high until rst_n or por_n is asserted. The count then stops.
- R7: Writing 1 to CTRL bit 0 arms the watchdog. A later write of 0 does not disarm it, and writes to CTRL bit 1 are ignored while armed.
- R8: In debug mode (CTRL bit 1 = 1), expiry raises irq instead of sys_rst_req. COUNT reloads from LIMIT and keeps running. irq (CTRL bit 4) stays high until the next completed feed.
- R9: Expiry sets CTRL bit 2. That bit, arm, mode and LIMIT are kept through rst_n and cleared only by por_n. rst_n stops the count (CTRL bit 3 = 0) and clears sys_rst_req and irq.
- R10: When a feed completes on the same edge where the count would expire, the feed wins: no reset request is raised and a full new interval starts.
- R11: When armed but never fed, the count does not run and no expiry occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears all state |
| rst_n | input | 1 | System reset, active low, asynchronous; clears live state only |
| req_valid | input | 1 | Bus access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | Register select: 0 CTRL, 1 LIMIT, 2 FEED, 3 COUNT |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data |
| sys_rst_req | output | 1 | Reset request to the chip reset controller |
| irq | output | 1 | Expiry interrupt in debug mode |

## Verification
The critical overlap is a feed that completes on the same clock edge where the count would expire. The bench times the 0x55 write to land exactly 4*(LIMIT+1) edges after the previous feed. It then judges that sys_rst_req stays low, that the next expiry moves out by a full interval, and that the request does rise at that later edge. A voided feed is placed on the same timeline, so a broken sequence must leave the original expiry edge unchanged. Timeout clamping is swept over every value from 0 to 0x110.

// File: rtl/sentry_pkg.sv
package sentry_pkg;

    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_LIMIT = 2'd1,
        REG_FEED  = 2'd2,
        REG_COUNT = 2'd3
    } reg_sel_e;

    localparam int unsigned CTRL_ARM  = 0;
    localparam int unsigned CTRL_MODE = 1;
    localparam int unsigned CTRL_EXP  = 2;
    localparam int unsigned CTRL_RUN  = 3;
    localparam int unsigned CTRL_IRQ  = 4;

endpackage

// File: rtl/sentry_feed_seq.sv
module sentry_feed_seq #(
    parameter int unsigned KEY_W = 8,
    parameter logic [KEY_W-1:0] KEY_FIRST  = 8'hAA,
    parameter logic [KEY_W-1:0] KEY_SECOND = 8'h55
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic             acc_is_feed,
    input  logic [KEY_W-1:0] acc_key,
    output logic             feed_done
);

    typedef struct packed {
        logic primed;
    } seq_t;

    seq_t seq_d, seq_q;
    logic feed_wr;

    always_comb begin
        seq_d     = seq_q;
        feed_done = 1'b0;
        feed_wr   = acc_valid && acc_write && acc_is_feed;
        if (acc_valid) begin
            // every access breaks a pending sequence unless it is the first key
            feed_done    = feed_wr && seq_q.primed && (acc_key == KEY_SECOND);
            seq_d.primed = feed_wr && (acc_key == KEY_FIRST);
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    // R4: a completed feed always consumes the primed state
    a_r4_consume: assert property (@(posedge clk) disable iff (!arst_n)
        feed_done |=> !seq_q.primed);

endmodule

// File: rtl/sentry_countdown.sv
module sentry_countdown #(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned PRE_W = 2
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             auto_reload,
    output logic [CNT_W-1:0] count,
    output logic             running,
    output logic             expire
);

    localparam logic [PRE_W-1:0] PRE_LAST = '1;

    typedef struct packed {
        logic             running;
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] count;
    } cd_t;

    cd_t cd_d, cd_q;
    logic tick;

    always_comb begin
        cd_d   = cd_q;
        tick   = cd_q.running && (cd_q.pre == PRE_LAST);
        expire = tick && (cd_q.count == '0) && !load;
        if (load) begin
            cd_d.running = 1'b1;
            cd_d.pre     = '0;
            cd_d.count   = reload_val;
        end else if (cd_q.running) begin
            cd_d.pre = cd_q.pre + 1'b1;
            if (tick) begin
                if (cd_q.count == '0) begin
                    if (auto_reload) begin
                        cd_d.count = reload_val;
                    end else begin
                        cd_d.running = 1'b0;
                    end
                end else begin
                    cd_d.count = cd_q.count - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cd_q <= '0;
        end else begin
            cd_q <= cd_d;
        end
    end

    assign count   = cd_q.count;
    assign running = cd_q.running;

    // R5: between prescaler ticks the count holds
    a_r5_hold: assert property (@(posedge clk) disable iff (!arst_n)
        (cd_q.running && !load && (cd_q.pre != PRE_LAST)) |=> $stable(cd_q.count));

    // R3: a load lands the reload value and starts the count
    a_r3_load: assert property (@(posedge clk) disable iff (!arst_n)
        load |=> (cd_q.running && (cd_q.count == $past(reload_val))));

    // R11: an idle counter never moves
    a_r11_idle: assert property (@(posedge clk) disable iff (!arst_n)
        (!cd_q.running && !load) |=> $stable(cd_q.count));

endmodule

// File: rtl/sentry_wdt.sv
module sentry_wdt
    import sentry_pkg::*;
#(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned PRE_W = 2,
    parameter int unsigned KEY_W = 8,
    parameter logic [CNT_W-1:0] MIN_LIMIT  = 32'h0000_00FF,
    parameter logic [KEY_W-1:0] KEY_FIRST  = 8'hAA,
    parameter logic [KEY_W-1:0] KEY_SECOND = 8'h55
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [1:0]       req_addr,
    input  logic [CNT_W-1:0] req_wdata,
    output logic [CNT_W-1:0] rd_data,
    output logic             sys_rst_req,
    output logic             irq
);

    typedef struct packed {
        logic             arm;
        logic             mode;
        logic             expired;
        logic [CNT_W-1:0] limit;
    } sticky_t;

    typedef struct packed {
        logic rst_req;
        logic irq;
    } live_t;

    sticky_t sticky_d, sticky_q;
    live_t   live_d, live_q;

    logic             live_rst_n;
    logic             feed_done;
    logic             feed_load;
    logic             expire;
    logic             cnt_running;
    logic [CNT_W-1:0] cnt_value;
    logic             wr_hit;
    logic             rd_hit;
    reg_sel_e         sel;

    assign live_rst_n = rst_n & por_n;
    assign sel        = reg_sel_e'(req_addr);
    assign wr_hit     = req_valid && req_write;
    assign rd_hit     = req_valid && !req_write;
    assign feed_load  = feed_done && sticky_q.arm;

    sentry_feed_seq #(
        .KEY_W      (KEY_W),
        .KEY_FIRST  (KEY_FIRST),
        .KEY_SECOND (KEY_SECOND)
    ) u_feed (
        .clk         (clk),
        .arst_n      (live_rst_n),
        .acc_valid   (req_valid),
        .acc_write   (req_write),
        .acc_is_feed (sel == REG_FEED),
        .acc_key     (req_wdata[KEY_W-1:0]),
        .feed_done   (feed_done)
    );

    sentry_countdown #(
        .CNT_W (CNT_W),
        .PRE_W (PRE_W)
    ) u_count (
        .clk         (clk),
        .arst_n      (live_rst_n),
        .load        (feed_load),
        .reload_val  (sticky_q.limit),
        .auto_reload (sticky_q.mode),
        .count       (cnt_value),
        .running     (cnt_running),
        .expire      (expire)
    );

    always_comb begin
        sticky_d = sticky_q;
        live_d   = live_q;

        if (wr_hit && (sel == REG_CTRL)) begin
            sticky_d.arm = sticky_q.arm | req_wdata[CTRL_ARM];
            if (!sticky_q.arm) begin
                sticky_d.mode = req_wdata[CTRL_MODE];
            end
        end
        if (wr_hit && (sel == REG_LIMIT)) begin
            sticky_d.limit = (req_wdata < MIN_LIMIT) ? MIN_LIMIT : req_wdata;
        end

        if (expire) begin
            sticky_d.expired = 1'b1;
            if (sticky_q.mode) begin
                live_d.irq = 1'b1;
            end else begin
                live_d.rst_req = 1'b1;
            end
        end
        if (feed_load) begin
            live_d.irq = 1'b0;
        end

        rd_data = '0;
        if (rd_hit) begin
            unique case (sel)
                REG_CTRL: begin
                    rd_data[CTRL_ARM]  = sticky_q.arm;
                    rd_data[CTRL_MODE] = sticky_q.mode;
                    rd_data[CTRL_EXP]  = sticky_q.expired;
                    rd_data[CTRL_RUN]  = cnt_running;
                    rd_data[CTRL_IRQ]  = live_q.irq;
                end
                REG_LIMIT: rd_data = sticky_q.limit;
                REG_FEED:  rd_data = '0;
                REG_COUNT: rd_data = cnt_value;
                default:   rd_data = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            sticky_q       <= '0;
            sticky_q.limit <= MIN_LIMIT;
        end else begin
            sticky_q <= sticky_d;
        end
    end

    always_ff @(posedge clk or negedge live_rst_n) begin
        if (!live_rst_n) begin
            live_q <= '0;
        end else begin
            live_q <= live_d;
        end
    end

    assign sys_rst_req = live_q.rst_req;
    assign irq         = live_q.irq;

    // R7: arming is one-way and freezes the mode
    a_r7_arm_lock: assert property (@(posedge clk) disable iff (!por_n)
        sticky_q.arm |=> sticky_q.arm);
    a_r7_mode_lock: assert property (@(posedge clk) disable iff (!por_n)
        sticky_q.arm |=> $stable(sticky_q.mode));

    // R6: the reset request holds until a reset arrives
    a_r6_hold: assert property (@(posedge clk) disable iff (!live_rst_n)
        sys_rst_req |=> sys_rst_req);

    // R8: the two expiry outputs never coexist
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!live_rst_n)
        !(sys_rst_req && irq));

    // R2: the stored limit never falls below the floor
    a_r2_floor: assert property (@(posedge clk) disable iff (!por_n)
        sticky_q.limit >= MIN_LIMIT);

    // R9: the expiry flag is only cleared by power-on reset
    a_r9_sticky: assert property (@(posedge clk) disable iff (!por_n)
        sticky_q.expired |=> sticky_q.expired);

endmodule

// File: tb/sim_sentry_wdt.sv
`timescale 1ns/1ps
module sim_sentry_wdt;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_addr = 2'd0;
    logic [31:0] req_wdata = 32'd0;
    logic [31:0] rd_data;
    logic        sys_rst_req;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    sentry_wdt u0 (
        .clk         (clk),
        .por_n       (por_n),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .rd_data     (rd_data),
        .sys_rst_req (sys_rst_req),
        .irq         (irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    // called at a negedge; the access commits on the next posedge
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        #1 v = rd_data;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic feed();
        wr(2'd2, 32'hAA);
        wr(2'd2, 32'h55);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run hung, got 0x0 expected 0x1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int unsigned lim;
        @(negedge clk); idle(3);
        por_n = 1'b1; rst_n = 1'b1;
        idle(1);

        // R1 reset state
        rd(2'd0, v); chk("R1 ctrl", v, 32'h0);
        rd(2'd1, v); chk("R1 limit", v, 32'hFF);
        rd(2'd2, v); chk("R1 feed", v, 32'h0);
        rd(2'd3, v); chk("R1 count", v, 32'h0);
        chk("R1 rst_req", {31'd0, sys_rst_req}, 32'h0);
        chk("R1 irq", {31'd0, irq}, 32'h0);
        // R5: idle bus reads nothing
        #1 chk("R5 no-read", rd_data, 32'h0);

        // R2 clamp sweep
        for (int i = 0; i <= 32'h110; i++) begin
            wr(2'd1, i);
            rd(2'd1, v);
            chk("R2 limit", v, (i < 32'hFF) ? 32'hFF : i);
        end
        wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, v); chk("R2 max", v, 32'hFFFF_FFFF);
        wr(2'd1, 32'h1234_5678); rd(2'd1, v); chk("R2 mid", v, 32'h1234_5678);

        // R3 unarmed feed has no effect
        feed();
        rd(2'd0, v); chk("R3 unarmed ctrl", v, 32'h0);
        rd(2'd3, v); chk("R3 unarmed count", v, 32'h0);

        // R7 arm lock and mode lock
        wr(2'd0, 32'h1); rd(2'd0, v); chk("R7 arm", v, 32'h1);
        wr(2'd0, 32'h0); rd(2'd0, v); chk("R7 no disarm", v, 32'h1);
        wr(2'd0, 32'h2); rd(2'd0, v); chk("R7 mode locked", v, 32'h1);

        // R11 armed, never fed
        idle(2000);
        chk("R11 rst_req", {31'd0, sys_rst_req}, 32'h0);
        rd(2'd3, v); chk("R11 count", v, 32'h0);

        // R3/R5 feed and count
        lim = 32'h100;
        wr(2'd1, lim);
        feed();                      // now at negedge after feed edge F
        for (int k = 0; k < 12; k++) begin
            rd(2'd3, v);
            chk("R5 count", v, lim - (k / 4));
        end                          // now after F+12
        // R4 broken sequence: AA, read, 55
        wr(2'd2, 32'hAA); rd(2'd0, v); wr(2'd2, 32'h55);
        chk("R3 running", v & 32'h8, 32'h8);
        idle(4 * lim + 3 - 15);
        chk("R6 before expiry", {31'd0, sys_rst_req}, 32'h0);
        idle(1);
        chk("R4 void feed: expiry on time", {31'd0, sys_rst_req}, 32'h1);
        rd(2'd0, v); chk("R6 ctrl after expiry", v, 32'h5);
        idle(10);
        chk("R6 held", {31'd0, sys_rst_req}, 32'h1);
        chk("R6 no irq", {31'd0, irq}, 32'h0);

        // R9 system reset keeps sticky state
        rst_n = 1'b0; idle(1); rst_n = 1'b1; idle(1);
        chk("R9 rst_req cleared", {31'd0, sys_rst_req}, 32'h0);
        rd(2'd0, v); chk("R9 ctrl kept", v, 32'h5);
        rd(2'd1, v); chk("R9 limit kept", v, lim);

        // R10 feed on the expiry edge wins
        feed();                      // F
        idle(4 * lim + 2);
        feed();                      // 0x55 commits at F+4*lim+4
        chk("R10 no reset", {31'd0, sys_rst_req}, 32'h0);
        rd(2'd3, v); chk("R10 reloaded", v, lim);
        idle(4 * lim + 2);
        chk("R10 next before", {31'd0, sys_rst_req}, 32'h0);
        idle(1);
        chk("R10 next expiry", {31'd0, sys_rst_req}, 32'h1);

        // R9 power-on reset clears all
        por_n = 1'b0; rst_n = 1'b0; idle(1); por_n = 1'b1; rst_n = 1'b1; idle(1);
        rd(2'd0, v); chk("R9 por ctrl", v, 32'h0);
        rd(2'd1, v); chk("R9 por limit", v, 32'hFF);
        chk("R9 por rst_req", {31'd0, sys_rst_req}, 32'h0);

        // R8 debug mode
        wr(2'd0, 32'h3);
        wr(2'd1, lim);
        feed();
        idle(4 * lim + 3);
        chk("R8 before", {31'd0, irq}, 32'h0);
        idle(1);
        chk("R8 irq", {31'd0, irq}, 32'h1);
        chk("R8 no reset", {31'd0, sys_rst_req}, 32'h0);
        rd(2'd0, v); chk("R8 ctrl", v, 32'h1F);
        rd(2'd3, v); chk("R8 reload", v, lim);
        idle(20);
        chk("R8 irq held", {31'd0, irq}, 32'h1);
        feed();
        chk("R8 irq cleared by feed", {31'd0, irq}, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule